// File: doc/BRIEF.md
# Burst Read Address and Wait Sequencer

This block sits at the read side of a burst-capable NOR-style memory. It takes the host's address bus, chip enable, output enable and latch enable. It produces the word address for the memory array, a strobe that marks bus cycles carrying valid read data, and the WAIT pin together with that pin's output enable. The memory array, the sense path and the command decoder sit outside the block.

Two read modes exist. In asynchronous mode a transparent latch controlled by latch enable passes the address straight to the array, and the clock has no effect. In synchronous mode the start address is taken on a clock edge, rising or falling as configured, while latch enable is low. A programmable latency then follows. After it the block steps the address once per clock: it wraps inside an aligned group for 4-word and 8-word bursts, or counts upward without end for continuous bursts. A continuous burst runs across bank boundaries. The only extra cost when it crosses an 8-word boundary is one wait cycle. Configuration is written through a 9-bit word, and every reset returns it to asynchronous mode.

The data strobe has no ready input. A memory bus cannot stall the array once a burst is running, so the receiver must take every word in the cycle in which `dvalid` is high. It applies back-pressure only by raising chip enable, which ends the burst.

Top module: `burst_rd_seq`

## Requirements
- R1: While `rst_n` is low, `dvalid` and `wait_oe` are 0 and `cfg_wr` is ignored. A reset loads configuration word 9'h037, which selects asynchronous mode.
- R2: On a rising clock edge with `cfg_wr` high, `cfg_in` is loaded and takes effect from the next edge. The bit fields are: [8] synchronous mode, [7] capture on falling edge, [6] early WAIT, [5] WAIT active high, [4:3] burst length (00 = 4 words, 01 = 8 words, 1x = continuous), [2:0] latency.
- R3: In asynchronous mode `arr_addr` follows `addr_in` while `addr_lat_n` is low. While it is high, `arr_addr` holds the value present when it rose, whatever the clock does.
- R4: After reset, `dvalid` stays 0 until `ce_n` or `addr_lat_n` has had a falling edge. From then on, in asynchronous mode, `dvalid` = !`ce_n` && !`oe_n`.
- R5: In synchronous mode, with `ce_n` low, a burst starts from the address on `addr_in` at a clock edge where `addr_lat_n` is low. Bit [7] chooses the falling edge instead of the rising edge.
- R6: With latency code L (codes below 2 act as 2), the L cycles after capture are wait cycles showing the start address. One word per clock follows, each flagged by `dvalid` when `oe_n` is low.
- R7: A 4-word or 8-word burst visits each address of its aligned group once, starting at the captured address and wrapping. After that it goes idle, with `dvalid` 0 and WAIT inactive.
- R8: A continuous burst increments linearly and runs across bank boundaries. After a word whose address has low three bits 111, it inserts exactly one wait cycle that already shows the next address.
- R9: WAIT is active in wait cycles. In early mode it is instead active one cycle before each wait cycle that follows a known earlier cycle. Bit [5] selects an active-high level when set.
- R10: `wait_oe` is 1 exactly when `ce_n` is low and `rst_n` is high. `oe_n` affects neither `wait_oe` nor `wait_o`.
- R11: Raising `ce_n` ends any burst. After `ce_n` falls again, the block stays idle until a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_lat_n | input | 1 | Address latch enable, active low |
| addr_in | input | AW | Host address bus |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_in | input | 9 | Configuration word |
| arr_addr | output | AW | Word address to the array |
| dvalid | output | 1 | Read data valid on this bus cycle |
| wait_o | output | 1 | WAIT pin level |
| wait_oe | output | 1 | WAIT pin drive enable |

## Verification
A wrong burst state shows up at the ports within one clock. A skipped or extra latency cycle moves the first `dvalid` by one cycle. A bad wrap or increment puts a wrong `arr_addr` in the very next data cycle. A lost boundary stall makes WAIT stay inactive in the cycle after a word ending in 111. A bad arming state or latch value in asynchronous mode shows directly on `dvalid` or `arr_addr` in the same cycle. The bench therefore compares every port against a behavioural model on every clock, so any error is seen in the cycle it first appears.

// File: rtl/burst_rd_pkg.sv
`timescale 1ns/1ps
package burst_rd_pkg;

  localparam int LAT_W = 3;

  typedef struct packed {
    logic             sync_en;
    logic             fall_edge;
    logic             wait_early;
    logic             wait_hi;
    logic [1:0]       blen;
    logic [LAT_W-1:0] lat;
  } rd_cfg_t;

  localparam int CFG_W = $bits(rd_cfg_t);

  // asynchronous mode, WAIT active high, continuous, latency 7
  localparam rd_cfg_t CFG_RST = '{sync_en: 1'b0, fall_edge: 1'b0, wait_early: 1'b0,
                                  wait_hi: 1'b1, blen: 2'b10, lat: 3'd7};

  typedef enum logic [1:0] {SQ_IDLE, SQ_LAT, SQ_DATA, SQ_STALL} sq_state_t;

endpackage

// File: rtl/burst_cfg_reg.sv
`timescale 1ns/1ps
module burst_cfg_reg
  import burst_rd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cfg_wr,
  input  rd_cfg_t cfg_d,
  output rd_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_wr) cfg_q <= cfg_d;
  end

endmodule

// File: rtl/burst_addr_front.sv
`timescale 1ns/1ps
module burst_addr_front #(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          addr_lat_n,
  input  logic [AW-1:0] addr_in,
  input  logic          sync_en,
  input  logic          fall_edge,
  output logic [AW-1:0] lat_addr,
  output logic          armed,
  output logic          cap_vld,
  output logic [AW-1:0] cap_addr
);

  logic [AW-1:0] lat_q;
  logic          arm_ce, arm_le;
  logic          neg_vld;
  logic [AW-1:0] neg_addr;
  logic          rise_vld;

  // transparent address latch for asynchronous reads
  always_latch begin
    if (!rst_n)          lat_q <= '0;
    else if (!addr_lat_n) lat_q <= addr_in;
  end
  assign lat_addr = lat_q;

  // output data needs a falling chip enable or latch enable after reset
  always_ff @(negedge ce_n or negedge rst_n) begin
    if (!rst_n) arm_ce <= 1'b0;
    else        arm_ce <= 1'b1;
  end

  always_ff @(negedge addr_lat_n or negedge rst_n) begin
    if (!rst_n) arm_le <= 1'b0;
    else        arm_le <= 1'b1;
  end

  assign armed = arm_ce | arm_le;

  // falling-edge capture path, consumed by the sequencer on the next rising edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_vld  <= 1'b0;
      neg_addr <= '0;
    end else begin
      neg_vld  <= sync_en & ~ce_n & ~addr_lat_n;
      neg_addr <= addr_in;
    end
  end

  assign rise_vld = sync_en & ~ce_n & ~addr_lat_n;
  assign cap_vld  = fall_edge ? neg_vld  : rise_vld;
  assign cap_addr = fall_edge ? neg_addr : addr_in;

endmodule

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
module burst_seq
  import burst_rd_pkg::*;
#(
  parameter int AW    = 22,
  parameter int SEG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_en,
  input  logic             ce_n,
  input  logic             cap_vld,
  input  logic [AW-1:0]    cap_addr,
  input  logic [1:0]       blen,
  input  logic [LAT_W-1:0] lat,
  output logic [AW-1:0]    seq_addr,
  output logic             in_data,
  output logic             wait_now,
  output logic             wait_next
);

  localparam int          WCNT_W   = SEG_W + 1;
  localparam logic [AW-1:0] MASK_LONG  = AW'((1 << SEG_W) - 1);
  localparam logic [AW-1:0] MASK_SHORT = AW'((1 << (SEG_W - 1)) - 1);

  sq_state_t           st;
  logic [LAT_W-1:0]    cnt;
  logic [WCNT_W-1:0]   words;
  logic [AW-1:0]       addr;

  logic                fixed_len;
  logic [AW-1:0]       grp_mask;
  logic [AW-1:0]       addr_inc;
  logic [AW-1:0]       addr_wrap;
  logic                seg_end;
  logic [LAT_W-1:0]    lat_eff;
  logic [WCNT_W-1:0]   words_init;

  assign fixed_len  = ~blen[1];
  assign grp_mask   = blen[0] ? MASK_LONG : MASK_SHORT;
  assign addr_inc   = addr + 1'b1;
  assign addr_wrap  = (addr & ~grp_mask) | (addr_inc & grp_mask);
  assign seg_end    = &addr[SEG_W-1:0];
  assign lat_eff    = (lat < LAT_W'(2)) ? LAT_W'(2) : lat;
  assign words_init = blen[0] ? WCNT_W'(1 << SEG_W) : WCNT_W'(1 << (SEG_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      words <= '0;
      addr  <= '0;
    end else if (!sync_en || ce_n) begin
      st <= SQ_IDLE;
    end else if (cap_vld) begin
      st   <= SQ_LAT;
      cnt  <= lat_eff;
      addr <= cap_addr;
    end else begin
      unique case (st)
        SQ_LAT: begin
          if (cnt == LAT_W'(1)) begin
            st    <= SQ_DATA;
            words <= words_init;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_DATA: begin
          if (fixed_len) begin
            if (words == WCNT_W'(1)) begin
              st <= SQ_IDLE;
            end else begin
              addr  <= addr_wrap;
              words <= words - 1'b1;
            end
          end else begin
            addr <= addr_inc;
            if (seg_end) st <= SQ_STALL;
          end
        end
        SQ_STALL: st <= SQ_DATA;
        default:  st <= SQ_IDLE;
      endcase
    end
  end

  assign seq_addr  = addr;
  assign in_data   = (st == SQ_DATA);
  assign wait_now  = (st == SQ_LAT) || (st == SQ_STALL);
  assign wait_next = ((st == SQ_LAT) && (cnt > LAT_W'(1))) ||
                     ((st == SQ_DATA) && !fixed_len && seg_end);

endmodule

// File: rtl/burst_rd_seq.sv
`timescale 1ns/1ps
module burst_rd_seq
  import burst_rd_pkg::*;
#(
  parameter int AW    = 22,
  parameter int SEG_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          addr_lat_n,
  input  logic [AW-1:0] addr_in,
  input  logic          cfg_wr,
  input  logic [8:0]    cfg_in,
  output logic [AW-1:0] arr_addr,
  output logic          dvalid,
  output logic          wait_o,
  output logic          wait_oe
);

  rd_cfg_t       cfg_q;
  logic [AW-1:0] lat_addr;
  logic          armed;
  logic          cap_vld;
  logic [AW-1:0] cap_addr;
  logic [AW-1:0] seq_addr;
  logic          in_data;
  logic          wait_now;
  logic          wait_next;
  logic          wait_act;

  burst_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_wr (cfg_wr),
    .cfg_d  (rd_cfg_t'(cfg_in)),
    .cfg_q  (cfg_q)
  );

  burst_addr_front #(.AW(AW)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .addr_lat_n (addr_lat_n),
    .addr_in    (addr_in),
    .sync_en    (cfg_q.sync_en),
    .fall_edge  (cfg_q.fall_edge),
    .lat_addr   (lat_addr),
    .armed      (armed),
    .cap_vld    (cap_vld),
    .cap_addr   (cap_addr)
  );

  burst_seq #(.AW(AW), .SEG_W(SEG_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_en   (cfg_q.sync_en),
    .ce_n      (ce_n),
    .cap_vld   (cap_vld),
    .cap_addr  (cap_addr),
    .blen      (cfg_q.blen),
    .lat       (cfg_q.lat),
    .seq_addr  (seq_addr),
    .in_data   (in_data),
    .wait_now  (wait_now),
    .wait_next (wait_next)
  );

  assign arr_addr = cfg_q.sync_en ? seq_addr : lat_addr;
  assign dvalid   = armed & ~ce_n & ~oe_n & (cfg_q.sync_en ? in_data : 1'b1);
  assign wait_act = cfg_q.wait_early ? wait_next : wait_now;
  assign wait_o   = cfg_q.wait_hi ? wait_act : ~wait_act;
  assign wait_oe  = ~ce_n & rst_n;

endmodule

// File: rtl/burst_rd_chk.sv
`timescale 1ns/1ps
module burst_rd_chk #(
  parameter int AW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dvalid,
  input logic          wait_o,
  input logic          wait_oe,
  input logic [AW-1:0] arr_addr,
  input logic          sync_en,
  input logic          wait_early,
  input logic          wait_hi,
  input logic [1:0]    blen
);

  // R1: quiet outputs while held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!dvalid && !wait_oe));

  // R9: on-time WAIT is never active in a data cycle
  p_no_wait_on_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && !wait_early && dvalid && wait_oe) |-> (wait_o != wait_hi));

  // R7: consecutive words of a fixed burst stay in one aligned group
  p_wrap_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && !blen[1] && dvalid && $past(dvalid) && $past(sync_en) && ($past(blen) == blen))
    |-> (blen[0] ? (arr_addr[AW-1:3] == $past(arr_addr[AW-1:3]))
                 : (arr_addr[AW-1:2] == $past(arr_addr[AW-1:2]))));

  // R8: back-to-back continuous words are strictly sequential
  p_cont_linear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && blen[1] && dvalid && $past(dvalid) && $past(sync_en) && $past(blen[1]))
    |-> (arr_addr == $past(arr_addr) + 1'b1));

endmodule

bind burst_rd_seq burst_rd_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dvalid     (dvalid),
  .wait_o     (wait_o),
  .wait_oe    (wait_oe),
  .arr_addr   (arr_addr),
  .sync_en    (cfg_q.sync_en),
  .wait_early (cfg_q.wait_early),
  .wait_hi    (cfg_q.wait_hi),
  .blen       (cfg_q.blen)
);

// File: tb/burst_rd_seq_tb_top.sv
`timescale 1ns/1ps
module burst_rd_seq_tb_top;

  localparam int AW = 22;

  logic          clk = 1'b0;
  logic          rst_n, ce_n, oe_n, addr_lat_n, cfg_wr;
  logic [AW-1:0] addr_in;
  logic [8:0]    cfg_in;
  logic [AW-1:0] arr_addr;
  logic          dvalid, wait_o, wait_oe;

  always #2 clk = ~clk;

  burst_rd_seq #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr_lat_n(addr_lat_n),
    .addr_in(addr_in), .cfg_wr(cfg_wr), .cfg_in(cfg_in),
    .arr_addr(arr_addr), .dvalid(dvalid), .wait_o(wait_o), .wait_oe(wait_oe)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  string cur_req = "R1";

  // behavioural model: mode 0 idle, 1 latency, 2 data, 3 boundary stall
  logic [8:0]    m_cfg;
  int            m_mode, m_cnt, m_words;
  logic [AW-1:0] m_addr, m_held, m_neg_addr;
  bit            m_neg_vld, m_armed;

  task automatic model_reset();
    m_cfg = 9'h037; m_mode = 0; m_cnt = 0; m_words = 0;
    m_addr = '0; m_held = '0; m_neg_addr = '0; m_neg_vld = 0; m_armed = 0;
  endtask

  initial model_reset();

  always @(negedge ce_n)       if (rst_n === 1'b1) m_armed = 1;
  always @(negedge addr_lat_n) if (rst_n === 1'b1) m_armed = 1;
  always @(posedge addr_lat_n) if (rst_n === 1'b1) m_held = addr_in;

  always @(negedge clk) begin
    if (rst_n !== 1'b1) begin
      m_neg_vld = 0; m_neg_addr = '0;
    end else begin
      m_neg_vld  = m_cfg[8] && !ce_n && !addr_lat_n;
      m_neg_addr = addr_in;
    end
  end

  always @(posedge clk) begin
    bit cap;
    int n, base;
    if (rst_n !== 1'b1) model_reset();
    else begin
      cap = m_cfg[8] && !ce_n && (m_cfg[7] ? m_neg_vld : !addr_lat_n);
      if (!m_cfg[8] || ce_n) m_mode = 0;
      else if (cap) begin
        m_mode = 1;
        m_cnt  = (m_cfg[2:0] < 2) ? 2 : int'(m_cfg[2:0]);
        m_addr = m_cfg[7] ? m_neg_addr : addr_in;
      end else begin
        case (m_mode)
          1: if (m_cnt == 1) begin m_mode = 2; m_words = m_cfg[3] ? 8 : 4; end
             else m_cnt--;
          2: if (!m_cfg[4]) begin
               if (m_words == 1) m_mode = 0;
               else begin
                 n = m_cfg[3] ? 8 : 4;
                 base = int'(m_addr) - (int'(m_addr) % n);
                 m_addr = AW'(base + ((int'(m_addr) - base + 1) % n));
                 m_words--;
               end
             end else begin
               if (m_addr % 8 == 7) m_mode = 3;
               m_addr = m_addr + 1;
             end
          3: m_mode = 2;
          default: m_mode = 0;
        endcase
      end
      if (cfg_wr) m_cfg = cfg_in;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // compare every port once per clock, away from both edges
  always @(posedge clk) begin
    logic          e_oe, e_dv, w_on, w_early, w;
    logic [AW-1:0] e_addr;
    #1.5;
    if (rst_n !== 1'b1) model_reset();
    e_oe    = !ce_n && (rst_n === 1'b1);
    w_on    = (m_mode == 1) || (m_mode == 3);
    w_early = ((m_mode == 1) && (m_cnt > 1)) || ((m_mode == 2) && m_cfg[4] && (m_addr % 8 == 7));
    w       = m_cfg[6] ? w_early : w_on;
    e_dv    = m_armed && !ce_n && !oe_n && (m_cfg[8] ? (m_mode == 2) : 1'b1);
    e_addr  = m_cfg[8] ? m_addr : (!addr_lat_n ? addr_in : m_held);
    chk("wait_oe", 32'(wait_oe), 32'(e_oe));
    chk("dvalid", 32'(dvalid), 32'(e_dv));
    chk("arr_addr", 32'(arr_addr), 32'(e_addr));
    if (e_oe) chk("wait_o", 32'(wait_o), 32'(m_cfg[5] ? w : !w));
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL %s watchdog expired actual=%0d expected=%0d", cur_req, cyc, 20000);
      finish_run();
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic load_cfg(logic [8:0] c);
    cfg_in = c; cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
  endtask

  task automatic start_burst(logic [AW-1:0] a);
    addr_in = a; addr_lat_n = 1'b0; tick(); addr_lat_n = 1'b1;
  endtask

  // address changes just after the falling edge, before the rising edge
  task automatic start_split(logic [AW-1:0] a, logic [AW-1:0] b);
    addr_in = a; addr_lat_n = 1'b0; #1.5; addr_in = b; tick(); addr_lat_n = 1'b1;
  endtask

  task automatic ce_pulse();
    ce_n = 1'b1; tick(); ce_n = 1'b0; tick();
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; addr_lat_n = 1'b1;
    addr_in = '0; cfg_wr = 1'b0; cfg_in = '0;
    // R1: reset quiet, config write ignored during reset
    cur_req = "R1";
    idle(1); cfg_in = 9'h1FF; cfg_wr = 1'b1; idle(2); cfg_wr = 1'b0;
    rst_n = 1'b1;
    // R4: no output data until a falling chip enable or latch enable
    cur_req = "R4";
    addr_in = 22'h000123; idle(3);
    // R3: transparent latch, then hold
    cur_req = "R3";
    addr_lat_n = 1'b0;
    for (int i = 1; i < 5; i++) begin addr_in = AW'(i * 22'h1111); tick(); end
    addr_lat_n = 1'b1; tick();
    addr_in = 22'h02AAAA; idle(3);
    // R10: output enable gates neither WAIT nor its enable
    cur_req = "R10";
    oe_n = 1'b1; idle(2); oe_n = 1'b0; tick();
    // R2: configuration load
    cur_req = "R2";
    load_cfg(9'h123); idle(2);
    // R7: 4-word and 8-word wrap
    cur_req = "R7";
    start_burst(22'h000006); idle(8);
    load_cfg(9'h12A); start_burst(22'h00001D); idle(12);
    // R6: latency clamp and maximum latency
    cur_req = "R6";
    load_cfg(9'h120); start_burst(22'h000040); idle(8);
    load_cfg(9'h127); start_burst(22'h000080); idle(14);
    // R8: continuous across a bank boundary
    cur_req = "R8";
    load_cfg(9'h134); start_burst(22'h03FFFD); idle(16);
    // R11: chip enable ends a burst
    cur_req = "R11";
    start_burst(22'h000100); idle(6); ce_n = 1'b1; idle(2); ce_n = 1'b0; idle(3);
    // R9: early WAIT, both polarities
    cur_req = "R9";
    load_cfg(9'h155); start_burst(22'h000005); idle(16); ce_pulse();
    load_cfg(9'h16B); start_burst(22'h000033); idle(14);
    // R5: falling-edge versus rising-edge capture
    cur_req = "R5";
    load_cfg(9'h1A2); start_split(22'h000200, 22'h000300); idle(8);
    load_cfg(9'h122); start_split(22'h000200, 22'h000300); idle(8);
    // R1: reset restores asynchronous mode
    cur_req = "R1";
    rst_n = 1'b0; idle(2); rst_n = 1'b1; addr_lat_n = 1'b0;
    for (int i = 0; i < 3; i++) begin addr_in = AW'(22'h001357 + i); tick(); end
    addr_lat_n = 1'b1; idle(2);
    finish_run();
  end

endmodule